// File: doc/BRIEF.md
# Serial Memory Command Front-End (two-wire target)

This block is the bus-facing half of a 64-Kbit serial memory. It watches an oversampled two-wire bus (clock and data), cleans both lines with a synchroniser and a stability filter, and picks out START and STOP conditions. It then walks the command protocol as a target. It checks the control byte against a fixed type code and three strap pins, and it takes a two-byte word address. Data bytes go to a write-cache port. For reads, bytes are fetched through a synchronous read port and shifted out MSB first. Commands whose first address byte has its top bit set go to a configuration port and never touch memory.

The block keeps one 13-bit address pointer for all of these accesses. Writes advance it inside a 64-byte window, the way the downstream cache is organised. Reads advance it across the whole 8 K space and wrap at the top. A STOP that closes a write carrying data raises a one-cycle commit strobe. While the downstream write cycle is busy, the block stays silent to control bytes, so a master can poll until it gets an ACK.

Top module: `serial_mem_fe`

## Requirements
- R1: The control byte is received MSB first. Bits 7:4 must equal 1010, bits 3:1 must equal `sel_strap`, and bit 0 selects the direction (1 = read, 0 = write). The block pulls SDA low in the ninth clock only when bits 7:1 all match; otherwise it leaves SDA released and ignores the bus until the next START.
- R2: While `wr_busy` is high, no control byte is acknowledged, matching or not. The same control byte is acknowledged once `wr_busy` is low.
- R3: After a write control byte, two address bytes follow, high byte first. The pointer becomes {high[4:0], low[7:0]}, so bits 6:5 of the high byte have no effect. Each later data byte is acknowledged and produces one `cw_valid` pulse, with `cw_addr` set to the pointer and `cw_data` set to the byte.
- R4: After each written byte, the low six pointer bits count up modulo 64 and the upper seven bits stay fixed (0x0FFF is followed by 0x0FC0).
- R5: A repeated START after the address bytes keeps the loaded pointer and does not raise `wr_start`. A read control byte that follows returns the byte at that address.
- R6: In a read, the block fetches through `rd_req`/`rd_addr`, with `rd_data` valid in the cycle after `rd_req`. A master ACK after a byte brings the next address, and 0x1FFF is followed by 0x0000. After a master NACK, SDA stays released until the next START or STOP.
- R7: A read control byte without a preceding address returns the byte one past the last byte read or written.
- R8: A STOP that closes a write in which at least one data byte was accepted pulses `wr_start` high for exactly one cycle. A write that ends with no data byte raises no pulse.
- R9: When bit 7 of the first address byte is 1, every byte of the command, that address byte included, is acknowledged and passed to `cfg_valid`/`cfg_data`. `cfg_index` runs 0, 1, 2 and then stays at 3. The closing STOP pulses `cfg_done`. No cache write and no `wr_start` occur.
- R10: A level change on SCL or SDA that lasts fewer than `FILT_LEN` clock cycles is ignored. In particular, a short SDA dip while SCL is high is not taken as START or STOP.
- R11: A START or STOP in the middle of a byte abandons that byte, releases SDA, and causes no cache write. After a START, the next byte is treated as a control byte.
- R12: During and right after reset, SDA is released and every strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| sel_strap | input | 3 | Device select straps compared with control-byte bits 3:1 |
| wr_busy | input | 1 | Downstream write cycle in progress |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| cw_valid | output | 1 | One-cycle write strobe to the cache |
| cw_addr | output | 13 | Address of the cached byte |
| cw_data | output | 8 | Byte to cache |
| wr_start | output | 1 | One-cycle commit strobe at a write-closing STOP |
| rd_req | output | 1 | One-cycle read fetch request |
| rd_addr | output | 13 | Fetch address |
| rd_data | input | 8 | Fetched byte, valid the cycle after `rd_req` |
| cfg_valid | output | 1 | One-cycle strobe for a configuration-command byte |
| cfg_index | output | 2 | Position of that byte in the command (saturates at 3) |
| cfg_data | output | 8 | Configuration-command byte |
| cfg_done | output | 1 | One-cycle strobe at the STOP closing a configuration command |

## Verification
The bench builds the block with `FILT_LEN` = 3 and drives the bus at ten system clocks per quarter bit. At that setting a two-cycle SDA dip in the middle of a data bit is short enough to test the filter, and a full 64-byte address window and the 0x1FFF wrap stay within a short run. With the straps at 101, a control byte can be wrong in its select field alone or in its type code alone, and the bench tries each case separately. The ordering of the transactions gives the current-address reads a known history: one follows a windowed write and one follows a wrapping sequential read.

// File: rtl/smfe_pkg.sv
package smfe_pkg;
  localparam int SMFE_AW   = 13;  // memory address bits
  localparam int SMFE_WIN  = 6;   // write window bits (64 bytes)
  localparam int SMFE_SELW = 3;   // strap bits in the control byte

  typedef logic [SMFE_AW-1:0] maddr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDATA, ST_CFG, ST_RDATA, ST_HOLD
  } fe_state_t;

  // Next address during sequential reads: full-space wrap.
  function automatic maddr_t seq_next(input maddr_t a);
    return a + maddr_t'(1);
  endfunction

  // Next address during writes: low window bits wrap, upper bits fixed.
  function automatic maddr_t win_next(input maddr_t a);
    logic [SMFE_WIN-1:0] lo;
    lo = a[SMFE_WIN-1:0] + {{(SMFE_WIN-1){1'b0}}, 1'b1};
    return {a[SMFE_AW-1:SMFE_WIN], lo};
  endfunction

  // Type code and strap comparison on a received control byte.
  function automatic logic ctrl_match(input logic [7:0] b,
                                      input logic [3:0] code,
                                      input logic [SMFE_SELW-1:0] strap);
    return (b[7:4] == code) && (b[3:1] == strap);
  endfunction
endpackage

// File: rtl/smfe_line_filter.sv
module smfe_line_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN) + 1;

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/smfe_cond_detect.sv
module smfe_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
endmodule

// File: rtl/serial_mem_fe.sv
module serial_mem_fe
  import smfe_pkg::*;
#(
  parameter int         FILT_LEN  = 4,
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter int         CFG_IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic [SMFE_SELW-1:0] sel_strap,
  input  logic                 wr_busy,
  output logic                 sda_drive_low,
  output logic                 cw_valid,
  output logic [SMFE_AW-1:0]   cw_addr,
  output logic [7:0]           cw_data,
  output logic                 wr_start,
  output logic                 rd_req,
  output logic [SMFE_AW-1:0]   rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 cfg_valid,
  output logic [CFG_IDX_W-1:0] cfg_index,
  output logic [7:0]           cfg_data,
  output logic                 cfg_done
);
  localparam int NLINES = 2;
  localparam int HI_W   = SMFE_AW - 8;

  // Line conditioning, one filter per bus line
  logic [NLINES-1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    smfe_line_filter #(.LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  // Bus events, brought out as named wires
  logic start_det, stop_det, scl_rise, scl_fall;

  smfe_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  // Protocol state
  fe_state_t            state, nxt_st;
  logic [3:0]           bit_idx;
  logic                 ack_ph;
  logic                 mack;
  logic                 data_seen;
  logic [7:0]           rx_sh, tx_sh, rbuf;
  logic [HI_W-1:0]      ahi;
  maddr_t               ptr;
  logic [CFG_IDX_W-1:0] cfg_cnt;
  logic                 rd_cap;
  logic                 sda_low;

  logic in_rx;
  logic byte_done;
  logic ctrl_done;
  assign in_rx     = (state == ST_CTRL) || (state == ST_AHI) || (state == ST_ALO) ||
                     (state == ST_WDATA) || (state == ST_CFG);
  assign byte_done = in_rx && scl_fall && (bit_idx == 4'd8) && !ack_ph;
  assign ctrl_done = byte_done && (state == ST_CTRL);

  assign sda_drive_low = sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt_st    <= ST_IDLE;
      bit_idx   <= '0;
      ack_ph    <= 1'b0;
      mack      <= 1'b0;
      data_seen <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rbuf      <= '0;
      ahi       <= '0;
      ptr       <= '0;
      cfg_cnt   <= '0;
      rd_cap    <= 1'b0;
      sda_low   <= 1'b0;
      cw_valid  <= 1'b0;
      cw_addr   <= '0;
      cw_data   <= '0;
      wr_start  <= 1'b0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      cfg_valid <= 1'b0;
      cfg_index <= '0;
      cfg_data  <= '0;
      cfg_done  <= 1'b0;
    end else begin
      cw_valid  <= 1'b0;
      wr_start  <= 1'b0;
      cfg_valid <= 1'b0;
      cfg_done  <= 1'b0;
      rd_req    <= 1'b0;
      rd_cap    <= rd_req;
      if (rd_cap) rbuf <= rd_data;

      if (start_det) begin
        state     <= ST_CTRL;
        bit_idx   <= '0;
        ack_ph    <= 1'b0;
        sda_low   <= 1'b0;
        data_seen <= 1'b0;
      end else if (stop_det) begin
        if (state == ST_WDATA && data_seen) wr_start <= 1'b1;
        if (state == ST_CFG) cfg_done <= 1'b1;
        state     <= ST_IDLE;
        bit_idx   <= '0;
        ack_ph    <= 1'b0;
        sda_low   <= 1'b0;
        data_seen <= 1'b0;
      end else if (in_rx) begin
        if (scl_rise && bit_idx < 4'd8) begin
          rx_sh   <= {rx_sh[6:0], sda_f};
          bit_idx <= bit_idx + 4'd1;
        end else if (byte_done) begin
          ack_ph <= 1'b1;
          case (state)
            ST_CTRL: begin
              if (ctrl_match(rx_sh, TYPE_CODE, sel_strap) && !wr_busy) begin
                sda_low <= 1'b1;
                if (rx_sh[0]) begin
                  rd_req  <= 1'b1;
                  rd_addr <= ptr;
                  nxt_st  <= ST_RDATA;
                end else begin
                  nxt_st  <= ST_AHI;
                end
              end else begin
                sda_low <= 1'b0;
                nxt_st  <= ST_IDLE;
              end
            end
            ST_AHI: begin
              sda_low <= 1'b1;
              ahi     <= rx_sh[HI_W-1:0];
              if (rx_sh[7]) begin
                cfg_valid <= 1'b1;
                cfg_index <= '0;
                cfg_data  <= rx_sh;
                cfg_cnt   <= CFG_IDX_W'(1);
                nxt_st    <= ST_CFG;
              end else begin
                nxt_st    <= ST_ALO;
              end
            end
            ST_ALO: begin
              sda_low <= 1'b1;
              ptr     <= {ahi, rx_sh};
              nxt_st  <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_low   <= 1'b1;
              cw_valid  <= 1'b1;
              cw_addr   <= ptr;
              cw_data   <= rx_sh;
              ptr       <= win_next(ptr);
              data_seen <= 1'b1;
              nxt_st    <= ST_WDATA;
            end
            default: begin
              sda_low   <= 1'b1;
              cfg_valid <= 1'b1;
              cfg_index <= cfg_cnt;
              cfg_data  <= rx_sh;
              if (cfg_cnt != '1) cfg_cnt <= cfg_cnt + CFG_IDX_W'(1);
              nxt_st    <= ST_CFG;
            end
          endcase
        end else if (scl_fall && ack_ph) begin
          ack_ph  <= 1'b0;
          bit_idx <= '0;
          state   <= nxt_st;
          if (nxt_st == ST_RDATA) begin
            tx_sh   <= rbuf;
            sda_low <= ~rbuf[7];
            ptr     <= seq_next(ptr);
          end else begin
            sda_low <= 1'b0;
          end
        end
      end else if (state == ST_RDATA) begin
        if (scl_rise) begin
          if (bit_idx == 4'd8) begin
            mack    <= ~sda_f;
            bit_idx <= 4'd9;
            if (!sda_f) begin
              rd_req  <= 1'b1;
              rd_addr <= ptr;
            end
          end else if (bit_idx < 4'd8) begin
            bit_idx <= bit_idx + 4'd1;
          end
        end else if (scl_fall) begin
          if (bit_idx >= 4'd1 && bit_idx <= 4'd7) begin
            tx_sh   <= {tx_sh[6:0], 1'b0};
            sda_low <= ~tx_sh[6];
          end else if (bit_idx == 4'd8) begin
            sda_low <= 1'b0;
          end else if (bit_idx == 4'd9) begin
            if (mack) begin
              tx_sh   <= rbuf;
              sda_low <= ~rbuf[7];
              ptr     <= seq_next(ptr);
              bit_idx <= '0;
            end else begin
              sda_low <= 1'b0;
              state   <= ST_HOLD;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/smfe_checker.sv
module smfe_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_busy,
  input logic ctrl_done,
  input logic stop_det,
  input logic sda_drive_low,
  input logic wr_start,
  input logic cw_valid,
  input logic cfg_valid,
  input logic rd_req
);
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_done && wr_busy |=> !sda_drive_low);  // R2
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);  // R8
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cw_valid, cfg_valid, wr_start}));  // R9
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);  // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low);  // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !sda_drive_low);  // R12
endmodule

bind serial_mem_fe smfe_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_busy      (wr_busy),
  .ctrl_done    (ctrl_done),
  .stop_det     (stop_det),
  .sda_drive_low(sda_drive_low),
  .wr_start     (wr_start),
  .cw_valid     (cw_valid),
  .cfg_valid    (cfg_valid),
  .rd_req       (rd_req)
);

// File: tb/serial_mem_fe_tb.sv
module serial_mem_fe_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_drive_low, cw_valid, wr_start, rd_req, cfg_valid, cfg_done;
  logic [12:0] cw_addr, rd_addr;
  logic [7:0] cw_data, rd_data, cfg_data;
  logic [1:0] cfg_index;
  wire sda_line = sda_m & ~sda_drive_low;

  always #4 clk = ~clk;  // 125 MHz

  serial_mem_fe #(.FILT_LEN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sel_strap(strap), .wr_busy(wr_busy), .sda_drive_low(sda_drive_low),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data),
    .wr_start(wr_start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .cfg_valid(cfg_valid), .cfg_index(cfg_index),
    .cfg_data(cfg_data), .cfg_done(cfg_done)
  );

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= pat(rd_addr);

  // Port monitors
  int n_cw = 0, n_ws = 0, n_cfg = 0, n_cd = 0;
  logic [12:0] cw_a [0:127];
  logic [7:0]  cw_d [0:127];
  logic [7:0]  cf_d [0:15];
  logic [1:0]  cf_i [0:15];
  always @(posedge clk) begin
    if (cw_valid && n_cw < 128) begin
      cw_a[n_cw] <= cw_addr; cw_d[n_cw] <= cw_data; n_cw <= n_cw + 1;
    end
    if (cfg_valid && n_cfg < 16) begin
      cf_d[n_cfg] <= cfg_data; cf_i[n_cfg] <= cfg_index; n_cfg <= n_cfg + 1;
    end
    if (wr_start) n_ws <= n_ws + 1;
    if (cfg_done) n_cd <= n_cd + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); b = sda_line; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic m_send(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) m_bit(v[i]);
    m_rbit(x);
    ack = ~x;
  endtask

  task automatic m_recv(output logic [7:0] v, input logic give_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin m_rbit(x); v[i] = x; end
    m_bit(~give_ack);
  endtask

  localparam logic [7:0] CW_B = 8'hAA;  // 1010 101 0
  localparam logic [7:0] CR_B = 8'hAB;  // 1010 101 1

  // R12: reset state
  task automatic t_reset();
    @(negedge clk);
    chk("R12 sda released", sda_drive_low, 0);
    chk("R12 cw_valid low", cw_valid, 0);
    chk("R12 wr_start low", wr_start, 0);
    chk("R12 rd_req low", rd_req, 0);
  endtask

  // R1 / R2: control byte matching and busy silence
  task automatic t_ctrl();
    logic a;
    int ws0 = n_ws;
    m_start(); m_send(8'hA2, a); chk("R1 wrong select nack", a, 0); m_stop();
    m_start(); m_send(8'hBA, a); chk("R1 wrong type nack", a, 0); m_stop();
    wr_busy = 1'b1;
    m_start(); m_send(CW_B, a); chk("R2 busy nack", a, 0); m_stop();
    wr_busy = 1'b0;
    m_start(); m_send(CW_B, a); chk("R2 idle ack", a, 1); m_stop();
    wq(2);
    chk("R8 no commit without data", n_ws, ws0);
  endtask

  // R3 / R8: single byte write
  task automatic t_byte_write();
    logic a;
    int c0 = n_cw, ws0 = n_ws;
    m_start(); m_send(CW_B, a); chk("R1 match ack", a, 1);
    m_send(8'h01, a); m_send(8'h23, a); m_send(8'hA5, a);
    chk("R3 data ack", a, 1);
    m_stop(); wq(2);
    chk("R3 one cache write", n_cw, c0 + 1);
    chk("R3 cache addr", cw_a[c0], 13'h0123);
    chk("R3 cache data", cw_d[c0], 8'hA5);
    chk("R8 one commit", n_ws, ws0 + 1);
  endtask

  // R3: high address bits 6:5 ignored
  task automatic t_hi_mask();
    logic a;
    int c0 = n_cw;
    m_start(); m_send(CW_B, a); m_send(8'h61, a); m_send(8'h40, a); m_send(8'h3C, a);
    m_stop(); wq(2);
    chk("R3 masked addr", cw_a[c0], 13'h0140);
  endtask

  // R4: write pointer wraps inside 64-byte window
  task automatic t_window();
    logic a;
    int c0 = n_cw;
    m_start(); m_send(CW_B, a); m_send(8'h0F, a); m_send(8'hFE, a);
    m_send(8'h11, a); m_send(8'h22, a); m_send(8'h33, a);
    m_stop(); wq(2);
    chk("R4 addr0", cw_a[c0], 13'h0FFE);
    chk("R4 addr1", cw_a[c0 + 1], 13'h0FFF);
    chk("R4 addr2 wraps in window", cw_a[c0 + 2], 13'h0FC0);
    chk("R4 data2", cw_d[c0 + 2], 8'h33);
  endtask

  // R7: current-address read
  task automatic t_cur_read(input logic [12:0] exp_a, input string tag);
    logic a;
    logic [7:0] v;
    m_start(); m_send(CR_B, a); chk({tag, " ack"}, a, 1);
    m_recv(v, 1'b0); m_stop();
    chk({tag, " data"}, v, pat(exp_a));
  endtask

  // R5: random read
  task automatic t_random_read();
    logic a;
    logic [7:0] v;
    int ws0 = n_ws;
    m_start(); m_send(CW_B, a); m_send(8'h04, a); m_send(8'h56, a);
    m_start(); m_send(CR_B, a); chk("R5 read ack", a, 1);
    m_recv(v, 1'b0); m_stop(); wq(2);
    chk("R5 random data", v, pat(13'h0456));
    chk("R5 no commit", n_ws, ws0);
  endtask

  // R6: sequential read with wrap and NACK release
  task automatic t_seq_read();
    logic a, x;
    logic [7:0] v0, v1;
    m_start(); m_send(CW_B, a); m_send(8'h1F, a); m_send(8'hFF, a);
    m_start(); m_send(CR_B, a);
    m_recv(v0, 1'b1); m_recv(v1, 1'b0);
    chk("R6 first byte", v0, pat(13'h1FFF));
    chk("R6 wrapped byte", v1, pat(13'h0000));
    m_rbit(x); chk("R6 released after nack", x, 1);
    m_rbit(x); chk("R6 still released", x, 1);
    m_stop();
  endtask

  // R9: configuration command
  task automatic t_config();
    logic a;
    int c0 = n_cw, ws0 = n_ws, f0 = n_cfg, d0 = n_cd;
    m_start(); m_send(CW_B, a); m_send(8'h8A, a); chk("R9 cfg ack", a, 1);
    m_send(8'h33, a); m_send(8'h5C, a); m_send(8'h77, a); m_send(8'h11, a);
    m_stop(); wq(2);
    chk("R9 cfg count", n_cfg, f0 + 5);
    chk("R9 idx0", cf_i[f0], 0);
    chk("R9 data0", cf_d[f0], 8'h8A);
    chk("R9 idx2", cf_i[f0 + 2], 2);
    chk("R9 idx saturates", cf_i[f0 + 4], 3);
    chk("R9 data4", cf_d[f0 + 4], 8'h11);
    chk("R9 done", n_cd, d0 + 1);
    chk("R9 no cache write", n_cw, c0);
    chk("R9 no commit", n_ws, ws0);
  endtask

  // R10: short SDA dip during SCL high is ignored
  task automatic t_glitch();
    logic a;
    int c0 = n_cw, ws0 = n_ws;
    logic [7:0] v = 8'h9C;
    m_start(); m_send(CW_B, a); m_send(8'h03, a); m_send(8'h10, a);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    sda_m = 1'b0; @(negedge clk); @(negedge clk); sda_m = 1'b1;
    repeat (Q - 2) @(negedge clk); scl_m = 1'b0; wq(1);
    for (int i = 6; i >= 0; i--) m_bit(v[i]);
    m_rbit(a);
    m_stop(); wq(2);
    chk("R10 byte survives glitch", n_cw, c0 + 1);
    chk("R10 data", cw_d[c0], 8'h9C);
    chk("R10 commit", n_ws, ws0 + 1);
  endtask

  // R11: STOP / START inside a byte
  task automatic t_abort();
    logic a;
    logic [7:0] v;
    int c0 = n_cw, ws0 = n_ws;
    m_start(); m_send(CW_B, a); m_send(8'h02, a); m_send(8'h00, a);
    m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b1);
    m_stop(); wq(2);
    chk("R11 partial byte dropped", n_cw, c0);
    chk("R11 no commit", n_ws, ws0);
    m_start(); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
    m_start(); m_send(CR_B, a); chk("R11 ctrl after restart", a, 1);
    m_recv(v, 1'b0); m_stop();
    chk("R11 read after abort", v, pat(13'h0200));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ctrl();
    t_byte_write();
    t_hi_mask();
    t_window();
    t_cur_read(13'h0FC1, "R7 after write");
    t_random_read();
    t_seq_read();
    t_cur_read(13'h0001, "R7 after wrap");
    t_config();
    t_glitch();
    t_abort();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule